// File: doc/BRIEF.md
# Thermal Clock Modulation Controller

This block protects a processor core from overheating by throttling its clock enable. A modulation engine splits time into eight slots of a programmable prescaled tick and lets the clock run for N of those slots. Two sources can start it. The automatic path starts when the sensor reports the trip temperature, or when an outside agent pulls the shared hot pin, and it always uses half duty. The on-demand path starts from a control bit and uses a programmed duty in eighths. The automatic path wins whenever both are requesting.

The block also drives the shared hot pin (as an open-drain request) while the die is hot, and it respects stop-grant rules for that pin. It raises single-cycle interrupts when the relative temperature crosses either programmable threshold and on every edge of the hot pin. A catastrophic-temperature flag latches a shutdown output that forces the clock enable low. The same flag sets a sticky out-of-spec status bit.

All pin levels are logical and active high: `hot_pin_i` is the received level of the shared pin, and `hot_pin_drive_o` = 1 means the pin is pulled to its asserted level.

Top module: `thm_throttle`

## Requirements
- R1: After reset, core_clk_en_o = 1, mod_active_o = 0, hot_o = 0, hot_pin_drive_o = 0, therm_trip_o = 0, oos_o = 0, and both interrupt outputs are 0.
- R2: A write with cfg_we_i = 1 takes effect at that clock edge. The addresses are: 0 = control, 1 = prescale, 2 = status clear, 3 + i = threshold i. In the control byte, bit 0 is the automatic enable, bit 4 is the on-demand enable and bits 3:1 are the duty field.
- R3: While modulation is active, each slot lasts (prescale + 1) cycles and eight slots form one period. Counting from the first active cycle, the clock is enabled during slots 0 to N-1 and disabled for the rest of the period. While modulation is inactive and no shutdown is latched, core_clk_en_o = 1.
- R4: With the on-demand enable set and no automatic request, modulation is active at any temperature with N equal to the duty field. A duty field of 0 gives N = 4.
- R5: The automatic request is the automatic enable combined with an internal hot state or an external pin request. It activates modulation with N = 4, and it overrides any on-demand duty. With the automatic enable clear, an internal hot state alone does not activate modulation.
- R6: The internal hot state (hot_o) sets one cycle after trip_flag_i. It stays set until clear_flag_i is seen with trip_flag_i low, and clears one cycle after that.
- R7: Outside stop-grant, hot_pin_drive_o follows hot_o with one cycle of delay.
- R8: While stop_grant_i = 1, the hot pin is not newly driven. If it is already driven, it stays driven until stop-grant ends and hot_o is clear.
- R9: An external pin request is the hot pin level after two synchronizer stages, ignored while the block is driving the pin or has driven it within the synchronizer window. It causes modulation only when the automatic enable is set, and it stops once the external agent releases the pin.
- R10: pin_irq_o pulses for one cycle on each rising and each falling edge of the synchronized pin level, two cycles after the pin changes.
- R11: For each threshold i, thr_irq_o[i] pulses for one cycle, one cycle after the result of (temp_rel_i <= threshold i) changes, in either direction.
- R12: cat_flag_i sets therm_trip_o on the next edge regardless of every enable and mode. therm_trip_o then stays set until reset and holds core_clk_en_o low.
- R13: oos_o sets on the next edge after cat_flag_i. A write of bit 0 = 1 to the status clear address clears it, but only in a cycle where cat_flag_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | ADDR_W | Register write address |
| cfg_wdata_i | input | DATA_W | Register write data |
| trip_flag_i | input | 1 | Sensor flag: die at trip temperature |
| clear_flag_i | input | 1 | Sensor flag: die below the hysteresis release point |
| temp_rel_i | input | TEMP_W | Degrees below maximum junction temperature |
| hot_pin_i | input | 1 | Received level of the shared hot pin |
| cat_flag_i | input | 1 | Catastrophic-temperature flag |
| stop_grant_i | input | 1 | Core is in stop-grant |
| core_clk_en_o | output | 1 | Core clock enable |
| hot_pin_drive_o | output | 1 | Pull the shared hot pin to its asserted level |
| therm_trip_o | output | 1 | Latched thermal shutdown |
| thr_irq_o | output | NUM_THR | Threshold crossing pulses, bit i for threshold i |
| pin_irq_o | output | 1 | Hot pin edge pulse |
| mod_active_o | output | 1 | Modulation active |
| hot_o | output | 1 | Internal hot state |
| oos_o | output | 1 | Sticky out-of-spec status |

## Verification
A slot or prescale counter that is off by even one shows up at core_clk_en_o within the first period after activation. The bench therefore compares every cycle of one or two whole periods against the slot index computed from the cycle number. A wrong hysteresis or pin-holding state appears on hot_o or hot_pin_drive_o one cycle after the sensor flag or stop-grant change that should have moved it. Such a fault is checked while stop-grant is both entered and left with the pin driven. A bad synchronizer length or drive mask appears two cycles after a pin edge, either as a misplaced pin_irq_o pulse or as modulation starting from the block's own drive.

// File: rtl/thm_pkg.sv
package thm_pkg;
   // duty field width; one modulation period has 2**DUTY_W slots
   localparam int unsigned DUTY_W = 3;

   // register addresses
   localparam int unsigned ADR_CTRL     = 0;
   localparam int unsigned ADR_PRESC    = 1;
   localparam int unsigned ADR_STCLR    = 2;
   localparam int unsigned ADR_THR_BASE = 3;

   // control byte: bit 4 on-demand enable, bits 3:1 duty, bit 0 automatic enable
   typedef struct packed {
      logic              od_en;
      logic [DUTY_W-1:0] duty;
      logic              auto_en;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/thm_regs.sv
module thm_regs
   import thm_pkg::*;
#(
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned TEMP_W  = 7,
   parameter int unsigned PRESC_W = 8,
   parameter int unsigned NUM_THR = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we_i,
   input  logic [ADDR_W-1:0]                addr_i,
   input  logic [DATA_W-1:0]                wdata_i,
   output ctrl_t                            ctrl_o,
   output logic [PRESC_W-1:0]               presc_o,
   output logic [NUM_THR-1:0][TEMP_W-1:0]   thr_o,
   output logic                             oos_clr_o
);
   logic hit_ctrl, hit_presc;

   assign hit_ctrl  = we_i && (addr_i == ADDR_W'(ADR_CTRL));
   assign hit_presc = we_i && (addr_i == ADDR_W'(ADR_PRESC));
   assign oos_clr_o = we_i && (addr_i == ADDR_W'(ADR_STCLR)) && wdata_i[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_o  <= '0;
         presc_o <= '0;
      end else begin
         if (hit_ctrl)  ctrl_o  <= ctrl_t'(wdata_i[CTRL_W-1:0]);
         if (hit_presc) presc_o <= wdata_i[PRESC_W-1:0];
      end
   end

   for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
      logic hit_w;
      assign hit_w = we_i && (addr_i == ADDR_W'(ADR_THR_BASE + g));
      always_ff @(posedge clk) begin
         if (!rst_n)     thr_o[g] <= '0;
         else if (hit_w) thr_o[g] <= wdata_i[TEMP_W-1:0];
      end
   end
endmodule

// File: rtl/thm_hotpin.sv
module thm_hotpin #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trip_i,
   input  logic clear_i,
   input  logic stop_grant_i,
   input  logic pin_i,
   output logic hot_o,
   output logic drive_o,
   output logic ext_req_o,
   output logic pin_irq_o
);
   logic                   hot_q, drive_q, pin_prev_q;
   logic [SYNC_STAGES-1:0] sync_q, drv_hist_q;
   logic                   pin_s, own_mask;

   // hysteresis: trip sets, clear releases, trip wins a tie
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hot_q      <= 1'b0;
         drive_q    <= 1'b0;
         pin_prev_q <= 1'b0;
      end else begin
         if (trip_i)       hot_q <= 1'b1;
         else if (clear_i) hot_q <= 1'b0;
         // new assertion blocked in stop-grant; an existing one is held through it
         drive_q    <= (hot_q && !stop_grant_i) || (drive_q && (stop_grant_i || hot_q));
         pin_prev_q <= pin_s;
      end
   end

   if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sync_q     <= '0;
            drv_hist_q <= '0;
         end else begin
            sync_q     <= pin_i;
            drv_hist_q <= drive_q;
         end
      end
   end else begin : g_sync_chain
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sync_q     <= '0;
            drv_hist_q <= '0;
         end else begin
            sync_q     <= {sync_q[SYNC_STAGES-2:0], pin_i};
            drv_hist_q <= {drv_hist_q[SYNC_STAGES-2:0], drive_q};
         end
      end
   end

   assign pin_s     = sync_q[SYNC_STAGES-1];
   assign own_mask  = drive_q || (|drv_hist_q);
   assign ext_req_o = pin_s && !own_mask;
   assign pin_irq_o = pin_s ^ pin_prev_q;
   assign hot_o     = hot_q;
   assign drive_o   = drive_q;
endmodule

// File: rtl/thm_tirq.sv
module thm_tirq #(
   parameter int unsigned TEMP_W  = 7,
   parameter int unsigned NUM_THR = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [TEMP_W-1:0]              temp_i,
   input  logic [NUM_THR-1:0][TEMP_W-1:0] thr_i,
   output logic [NUM_THR-1:0]             irq_o
);
   logic primed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) primed_q <= 1'b0;
      else        primed_q <= 1'b1;
   end

   for (genvar g = 0; g < NUM_THR; g++) begin : g_cmp
      logic at_or_above_w, cmp_q, irq_q;
      // smaller reading means hotter
      assign at_or_above_w = (temp_i <= thr_i[g]);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cmp_q <= 1'b0;
            irq_q <= 1'b0;
         end else begin
            cmp_q <= at_or_above_w;
            irq_q <= primed_q && (at_or_above_w != cmp_q);
         end
      end
      assign irq_o[g] = irq_q;
   end
endmodule

// File: rtl/thm_mod.sv
module thm_mod
   import thm_pkg::*;
#(
   parameter int unsigned PRESC_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  ctrl_t              ctrl_i,
   input  logic [PRESC_W-1:0] presc_i,
   input  logic               hot_i,
   input  logic               ext_req_i,
   input  logic               shut_i,
   output logic               clk_en_o,
   output logic               active_o
);
   localparam int unsigned     SLOTS   = 1 << DUTY_W;
   localparam logic [DUTY_W:0] HALF_ON = (DUTY_W+1)'(SLOTS / 2);

   logic               auto_req, active;
   logic [DUTY_W:0]    n_on;
   logic [PRESC_W-1:0] pcnt_q;
   logic [DUTY_W-1:0]  slot_q;

   // automatic path has precedence over on-demand
   assign auto_req = ctrl_i.auto_en && (hot_i || ext_req_i);
   assign active   = auto_req || ctrl_i.od_en;

   always_comb begin
      if (auto_req || ctrl_i.duty == '0) n_on = HALF_ON;
      else                               n_on = {1'b0, ctrl_i.duty};
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         pcnt_q <= '0;
         slot_q <= '0;
      end else if (pcnt_q == presc_i) begin
         pcnt_q <= '0;
         slot_q <= slot_q + DUTY_W'(1);
      end else begin
         pcnt_q <= pcnt_q + PRESC_W'(1);
      end
   end

   assign clk_en_o = !shut_i && (!active || ({1'b0, slot_q} < n_on));
   assign active_o = active;
endmodule

// File: rtl/thm_throttle.sv
module thm_throttle
   import thm_pkg::*;
#(
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned TEMP_W      = 7,
   parameter int unsigned PRESC_W     = 8,
   parameter int unsigned NUM_THR     = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we_i,
   input  logic [ADDR_W-1:0]  cfg_addr_i,
   input  logic [DATA_W-1:0]  cfg_wdata_i,
   input  logic               trip_flag_i,
   input  logic               clear_flag_i,
   input  logic [TEMP_W-1:0]  temp_rel_i,
   input  logic               hot_pin_i,
   input  logic               cat_flag_i,
   input  logic               stop_grant_i,
   output logic               core_clk_en_o,
   output logic               hot_pin_drive_o,
   output logic               therm_trip_o,
   output logic [NUM_THR-1:0] thr_irq_o,
   output logic               pin_irq_o,
   output logic               mod_active_o,
   output logic               hot_o,
   output logic               oos_o
);
   // elaboration-time parameter checks
   if (DATA_W < CTRL_W || DATA_W < TEMP_W || DATA_W < PRESC_W) begin : g_bad_data_w
      $error("thm_throttle: DATA_W too narrow for a register field");
   end
   if (NUM_THR < 1 || (ADR_THR_BASE + NUM_THR) > (1 << ADDR_W)) begin : g_bad_thr
      $error("thm_throttle: thresholds do not fit the address space");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("thm_throttle: SYNC_STAGES must be at least 1");
   end

   ctrl_t                          ctrl;
   logic [PRESC_W-1:0]             presc;
   logic [NUM_THR-1:0][TEMP_W-1:0] thr;
   logic                           oos_clr, ext_req, trip_q, oos_q;

   thm_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TEMP_W(TEMP_W),
      .PRESC_W(PRESC_W), .NUM_THR(NUM_THR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
      .wdata_i(cfg_wdata_i), .ctrl_o(ctrl), .presc_o(presc), .thr_o(thr),
      .oos_clr_o(oos_clr)
   );

   thm_hotpin #(.SYNC_STAGES(SYNC_STAGES)) u_hotpin (
      .clk(clk), .rst_n(rst_n), .trip_i(trip_flag_i), .clear_i(clear_flag_i),
      .stop_grant_i(stop_grant_i), .pin_i(hot_pin_i), .hot_o(hot_o),
      .drive_o(hot_pin_drive_o), .ext_req_o(ext_req), .pin_irq_o(pin_irq_o)
   );

   thm_tirq #(.TEMP_W(TEMP_W), .NUM_THR(NUM_THR)) u_tirq (
      .clk(clk), .rst_n(rst_n), .temp_i(temp_rel_i), .thr_i(thr), .irq_o(thr_irq_o)
   );

   thm_mod #(.PRESC_W(PRESC_W)) u_mod (
      .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .presc_i(presc), .hot_i(hot_o),
      .ext_req_i(ext_req), .shut_i(trip_q), .clk_en_o(core_clk_en_o),
      .active_o(mod_active_o)
   );

   // catastrophic path: independent of every mode and enable
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trip_q <= 1'b0;
         oos_q  <= 1'b0;
      end else begin
         trip_q <= trip_q || cat_flag_i;
         if (cat_flag_i)   oos_q <= 1'b1;
         else if (oos_clr) oos_q <= 1'b0;
      end
   end

   assign therm_trip_o = trip_q;
   assign oos_o        = oos_q;
endmodule

// File: rtl/thm_throttle_chk.sv
module thm_throttle_chk (
   input logic clk,
   input logic rst_n,
   input logic trip_flag_i,
   input logic clear_flag_i,
   input logic cat_flag_i,
   input logic stop_grant_i,
   input logic core_clk_en_o,
   input logic hot_pin_drive_o,
   input logic therm_trip_o,
   input logic mod_active_o,
   input logic hot_o,
   input logic oos_o
);
   assert_idle_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mod_active_o && !therm_trip_o) |-> core_clk_en_o);

   assert_hot_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trip_flag_i |=> hot_o);

   assert_hot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_o && !clear_flag_i) |=> hot_o);

   assert_drive_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_o && !stop_grant_i) |=> hot_pin_drive_o);

   assert_sg_no_new_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_grant_i && !hot_pin_drive_o) |=> !hot_pin_drive_o);

   assert_sg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_grant_i && hot_pin_drive_o) |=> hot_pin_drive_o);

   assert_cat_latch_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cat_flag_i |=> therm_trip_o);

   assert_trip_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      therm_trip_o |=> therm_trip_o);

   assert_trip_gates_R12: assert property (@(posedge clk) disable iff (!rst_n)
      therm_trip_o |-> !core_clk_en_o);

   assert_oos_set_R13: assert property (@(posedge clk) disable iff (!rst_n)
      cat_flag_i |=> oos_o);
endmodule

bind thm_throttle thm_throttle_chk u_chk (
   .clk(clk), .rst_n(rst_n), .trip_flag_i(trip_flag_i), .clear_flag_i(clear_flag_i),
   .cat_flag_i(cat_flag_i), .stop_grant_i(stop_grant_i), .core_clk_en_o(core_clk_en_o),
   .hot_pin_drive_o(hot_pin_drive_o), .therm_trip_o(therm_trip_o),
   .mod_active_o(mod_active_o), .hot_o(hot_o), .oos_o(oos_o)
);

// File: tb/thm_throttle_tb.sv
module thm_throttle_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we_i = 1'b0;
   logic [2:0] cfg_addr_i = '0;
   logic [7:0] cfg_wdata_i = '0;
   logic       trip_flag_i = 1'b0, clear_flag_i = 1'b0;
   logic [6:0] temp_rel_i = 7'd50;
   logic       ext_drv = 1'b0, cat_flag_i = 1'b0, stop_grant_i = 1'b0;
   logic       hot_pin_i;
   logic       core_clk_en_o, hot_pin_drive_o, therm_trip_o, pin_irq_o;
   logic       mod_active_o, hot_o, oos_o;
   logic [1:0] thr_irq_o;
   int         total = 0, bad = 0;
   bit         done = 1'b0;

   localparam int A_CTRL = 0, A_PRESC = 1, A_STCLR = 2, A_THR0 = 3, A_THR1 = 4;

   always #4 clk = ~clk;

   // wired shared pin: outside agent or own drive
   assign hot_pin_i = ext_drv | hot_pin_drive_o;

   thm_throttle u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
      .cfg_wdata_i(cfg_wdata_i), .trip_flag_i(trip_flag_i), .clear_flag_i(clear_flag_i),
      .temp_rel_i(temp_rel_i), .hot_pin_i(hot_pin_i), .cat_flag_i(cat_flag_i),
      .stop_grant_i(stop_grant_i), .core_clk_en_o(core_clk_en_o),
      .hot_pin_drive_o(hot_pin_drive_o), .therm_trip_o(therm_trip_o),
      .thr_irq_o(thr_irq_o), .pin_irq_o(pin_irq_o), .mod_active_o(mod_active_o),
      .hot_o(hot_o), .oos_o(oos_o)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      cfg_we_i = 1'b1; cfg_addr_i = 3'(a); cfg_wdata_i = 8'(d);
      @(negedge clk);
      cfg_we_i = 1'b0;
   endtask

   // cycle i of an activation has slot (i / (p+1)) % 8; enabled while slot < n_on
   task automatic chk_pattern(input string req, input int n_on, input int p, input int periods);
      for (int i = 0; i < 8 * (p + 1) * periods; i++) begin
         chk(req, $sformatf("clk_en cycle %0d", i), 32'(core_clk_en_o),
             32'(((i / (p + 1)) % 8) < n_on));
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      chk("R1", "clk_en", 32'(core_clk_en_o), 1);
      chk("R1", "active", 32'(mod_active_o), 0);
      chk("R1", "hot", 32'(hot_o), 0);
      chk("R1", "drive", 32'(hot_pin_drive_o), 0);
      chk("R1", "trip", 32'(therm_trip_o), 0);
      chk("R1", "oos", 32'(oos_o), 0);
      chk("R1", "irqs", 32'({thr_irq_o, pin_irq_o}), 0);
   endtask

   task automatic t_ondemand;
      wr(A_PRESC, 0);
      wr(A_CTRL, 8'h16);              // R2: od_en bit4, duty 3 in bits 3:1
      chk("R2", "active after write", 32'(mod_active_o), 1);
      chk_pattern("R4", 3, 0, 2);
      wr(A_CTRL, 0);
      chk("R3", "idle clk_en", 32'(core_clk_en_o), 1);
      wr(A_CTRL, 8'h10);              // duty 0 -> half
      chk_pattern("R4", 4, 0, 1);
      wr(A_CTRL, 0);
      wr(A_PRESC, 1);
      wr(A_CTRL, 8'h1E);              // duty 7, two cycles per slot
      chk_pattern("R3", 7, 1, 2);
      wr(A_CTRL, 0);
      wr(A_PRESC, 0);
   endtask

   task automatic t_auto;
      wr(A_CTRL, 8'h01);
      chk("R5", "no hot no activation", 32'(mod_active_o), 0);
      @(negedge clk); trip_flag_i = 1'b1;
      @(negedge clk); trip_flag_i = 1'b0;
      chk("R6", "hot set", 32'(hot_o), 1);
      chk("R5", "auto active", 32'(mod_active_o), 1);
      chk_pattern("R5", 4, 0, 2);
      chk("R6", "hot held without clear", 32'(hot_o), 1);
      clear_flag_i = 1'b1;
      @(negedge clk); clear_flag_i = 1'b0;
      chk("R6", "hot released", 32'(hot_o), 0);
      chk("R3", "clk_en after release", 32'(core_clk_en_o), 1);
      repeat (4) @(negedge clk);
      wr(A_CTRL, 0);
      trip_flag_i = 1'b1;
      @(negedge clk); trip_flag_i = 1'b0;
      chk("R5", "hot without auto enable", 32'(mod_active_o), 0);
      wr(A_CTRL, 8'h1F);              // auto + on-demand duty 7
      chk_pattern("R5", 4, 0, 1);     // auto duty overrides
      clear_flag_i = 1'b1;
      @(negedge clk); clear_flag_i = 1'b0;
      wr(A_CTRL, 0);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_hotpin;
      wr(A_CTRL, 8'h01);
      @(negedge clk); trip_flag_i = 1'b1;
      @(negedge clk); trip_flag_i = 1'b0;
      chk("R7", "drive lags hot", 32'(hot_pin_drive_o), 0);
      @(negedge clk);
      chk("R7", "drive follows hot", 32'(hot_pin_drive_o), 1);
      clear_flag_i = 1'b1;
      @(negedge clk); clear_flag_i = 1'b0;
      chk("R7", "drive still on", 32'(hot_pin_drive_o), 1);
      @(negedge clk);
      chk("R7", "drive released", 32'(hot_pin_drive_o), 0);
      repeat (4) @(negedge clk);
      stop_grant_i = 1'b1; trip_flag_i = 1'b1;
      @(negedge clk); trip_flag_i = 1'b0;
      chk("R6", "hot in stop-grant", 32'(hot_o), 1);
      repeat (2) @(negedge clk);
      chk("R8", "no new drive in stop-grant", 32'(hot_pin_drive_o), 0);
      stop_grant_i = 1'b0;
      @(negedge clk);
      chk("R8", "drive after stop-grant exit", 32'(hot_pin_drive_o), 1);
      repeat (3) @(negedge clk);
      stop_grant_i = 1'b1; clear_flag_i = 1'b1;
      @(negedge clk); clear_flag_i = 1'b0;
      chk("R6", "hot cleared", 32'(hot_o), 0);
      repeat (3) @(negedge clk);
      chk("R8", "drive held in stop-grant", 32'(hot_pin_drive_o), 1);
      chk("R9", "own drive is not external", 32'(mod_active_o), 0);
      chk("R9", "clk_en with own drive", 32'(core_clk_en_o), 1);
      stop_grant_i = 1'b0;
      @(negedge clk);
      chk("R8", "drive drops on exit", 32'(hot_pin_drive_o), 0);
      repeat (2) @(negedge clk);
      chk("R9", "no activation on own release", 32'(mod_active_o), 0);
      repeat (3) @(negedge clk);
      wr(A_CTRL, 0);
   endtask

   task automatic t_extpin;
      @(negedge clk); ext_drv = 1'b1;
      @(negedge clk);
      chk("R10", "no pulse yet", 32'(pin_irq_o), 0);
      @(negedge clk);
      chk("R10", "rise pulse", 32'(pin_irq_o), 1);
      @(negedge clk);
      chk("R10", "pulse one cycle", 32'(pin_irq_o), 0);
      chk("R9", "ext ignored without auto", 32'(mod_active_o), 0);
      chk("R9", "clk_en without auto", 32'(core_clk_en_o), 1);
      wr(A_CTRL, 8'h01);
      chk_pattern("R9", 4, 0, 1);
      ext_drv = 1'b0;
      @(negedge clk);
      chk("R9", "still active in sync window", 32'(mod_active_o), 1);
      @(negedge clk);
      chk("R9", "released", 32'(mod_active_o), 0);
      chk("R10", "fall pulse", 32'(pin_irq_o), 1);
      chk("R9", "clk_en after release", 32'(core_clk_en_o), 1);
      @(negedge clk);
      chk("R10", "fall pulse one cycle", 32'(pin_irq_o), 0);
      wr(A_CTRL, 0);
   endtask

   task automatic t_thresh;
      wr(A_THR0, 10);
      wr(A_THR1, 20);
      repeat (2) @(negedge clk);
      chk("R11", "quiet above thresholds", 32'(thr_irq_o), 0);
      temp_rel_i = 7'd15;
      @(negedge clk); chk("R11", "cross thr1", 32'(thr_irq_o), 2'b10);
      @(negedge clk); chk("R11", "pulse ends", 32'(thr_irq_o), 0);
      temp_rel_i = 7'd5;
      @(negedge clk); chk("R11", "cross thr0", 32'(thr_irq_o), 2'b01);
      @(negedge clk); chk("R11", "pulse ends", 32'(thr_irq_o), 0);
      temp_rel_i = 7'd30;
      @(negedge clk); chk("R11", "both fall back", 32'(thr_irq_o), 2'b11);
      @(negedge clk); chk("R11", "pulse ends", 32'(thr_irq_o), 0);
      temp_rel_i = 7'd20;
      @(negedge clk); chk("R11", "equal counts as crossed", 32'(thr_irq_o), 2'b10);
      @(negedge clk);
   endtask

   task automatic t_cat;
      wr(A_CTRL, 8'h1C);
      @(negedge clk); cat_flag_i = 1'b1;
      @(negedge clk);
      chk("R12", "trip set", 32'(therm_trip_o), 1);
      chk("R12", "clk gated", 32'(core_clk_en_o), 0);
      chk("R13", "oos set", 32'(oos_o), 1);
      wr(A_STCLR, 1);
      chk("R13", "clear blocked while cat", 32'(oos_o), 1);
      cat_flag_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R12", "trip latched", 32'(therm_trip_o), 1);
      wr(A_CTRL, 0);
      chk("R12", "gated with modes off", 32'(core_clk_en_o), 0);
      wr(A_STCLR, 1);
      chk("R13", "oos cleared", 32'(oos_o), 0);
      chk("R12", "trip survives status clear", 32'(therm_trip_o), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ondemand();
      t_auto();
      t_hotpin();
      t_extpin();
      t_thresh();
      t_cat();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog all-requirements act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule